// File: doc/BRIEF.md
# Timed Register Trigger Generator

The block replays a table of timed writes to one register of a port controller. Each table entry is one word that holds two bytes: a value to write and a hold time in microseconds. After a start strobe, the generator issues a one-cycle write strobe carrying the value for entry 0. It then waits the hold time of that entry, moves to entry 1, and continues until the requested number of entries has been played. It then pulses a done flag. The waveform on the port pins is therefore set by the table alone, and no processor has to step through it.

The register address comes from a select input that is captured at start and held for the whole run. The entry count is also captured at start. The table sits in a memory outside the block. The block reads it through an address output and a data input. That read path is combinational: the word for the address appears in the same cycle. The hold time in clock cycles is the delay byte times `CYC_PER_US`, so one entry can hold for at most 255 us.

Top module: `trig_gen`

## Requirements
- R1: While reset is active and in the first cycle after it, `wr_o` and `done_o` are low and `mem_addr_o` is 0.
- R2: A start sampled while idle with a count N > 0 gives the first write strobe in the very next cycle. `wr_addr_o` carries the select value sampled with that start during every strobe of the run.
- R3: A table word holds the value to write in bits [7:0] and the hold time in us in bits [15:8]. During the i-th strobe (counted from 0), `mem_addr_o` equals i and `wr_data_o` equals bits [7:0] of word i.
- R4: After a strobe whose word has hold byte d, the next strobe of the run comes exactly d*CYC_PER_US+1 cycles later.
- R5: A hold byte of 0 makes the next strobe follow in the next cycle, so strobes appear back to back.
- R6: `done_o` is high for exactly one cycle. That cycle comes d*CYC_PER_US+1 cycles after the last strobe, where d is the hold byte of the last entry. No strobe is issued in the same cycle.
- R7: A start with count 0 gives `done_o` in the next cycle and no write strobe.
- R8: A start sampled while a run is in progress, including in the done cycle, is ignored. Its select and count are not used, and it produces no further strobes or done pulses.
- R9: A run with count N issues exactly N strobes, each one cycle long. `wr_data_o` is 0 in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, used only while idle |
| reg_sel_i | input | REG_W | Target register select, sampled at start |
| pair_cnt_i | input | ADDR_W+1 | Number of table entries to play, sampled at start |
| mem_addr_o | output | ADDR_W | Table read address, the current entry index |
| mem_data_i | input | 2*BYTE_W | Table word: hold byte in the upper half, value in the lower half |
| wr_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | REG_W | Register address for the write |
| wr_data_o | output | BYTE_W | Value for the write, 0 outside strobes |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
If the entry index is off, the very next strobe shows the wrong `mem_addr_o` and the wrong value. If the hold counter is wrong, the strobe or done cycle arrives early or late, and this is visible within one hold time. If the end of a run is judged wrong, the strobe count is wrong or `done_o` appears in the wrong cycle. A start that is taken while busy shows up as extra strobes, or as a changed `wr_addr_o`, in the cycle after it. For these reasons the bench compares strobe, value, address, index and done against its model in every cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } trig_state_e;
endpackage

// File: rtl/trig_index.sv
module trig_index #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W:0]   cnt_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic [ADDR_W:0]   cnt_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] idx_q;
  logic [ADDR_W:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      cnt_q <= cnt_i;
    end else if (inc_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign cnt_o  = cnt_q;
  assign last_o = ({1'b0, idx_q} == cnt_q - 1'b1);
endmodule

// File: rtl/trig_timer.sv
module trig_timer #(
  parameter int DLY_W      = 8,
  parameter int CYC_PER_US = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             zero_o,
  output logic             end_o
);
  localparam int TMR_W = DLY_W + $clog2(CYC_PER_US + 1);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= TMR_W'(dly_i) * TMR_W'(CYC_PER_US);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (dly_i == '0);
  // high in the final cycle of the hold window
  assign end_o  = (cnt_q == TMR_W'(1));
endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
  import trig_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        cnt_zero_i,
  input  logic        last_i,
  input  logic        dly_zero_i,
  input  logic        wait_end_i,
  output logic        idx_load_o,
  output logic        idx_inc_o,
  output logic        tmr_load_o,
  output logic        wr_o,
  output logic        done_o
);
  trig_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    idx_load_o = 1'b0;
    idx_inc_o  = 1'b0;
    tmr_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          idx_load_o = 1'b1;
          state_d    = cnt_zero_i ? ST_DONE : ST_WRITE;
        end
      end
      ST_WRITE: begin
        tmr_load_o = 1'b1;
        if (dly_zero_i) begin
          if (last_i) state_d = ST_DONE;
          else        idx_inc_o = 1'b1;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wait_end_i) begin
          if (last_i) begin
            state_d = ST_DONE;
          end else begin
            idx_inc_o = 1'b1;
            state_d   = ST_WRITE;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign wr_o   = (state_q == ST_WRITE);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/trig_gen.sv
module trig_gen #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 6,
  parameter int REG_W      = 3,
  parameter int CYC_PER_US = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [REG_W-1:0]    reg_sel_i,
  input  logic [ADDR_W:0]     pair_cnt_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [2*BYTE_W-1:0] mem_data_i,
  output logic                wr_o,
  output logic [REG_W-1:0]    wr_addr_o,
  output logic [BYTE_W-1:0]   wr_data_o,
  output logic                done_o
);
  logic              idx_load, idx_inc, tmr_load;
  logic              last, dly_zero, wait_end;
  logic [ADDR_W:0]   pair_cnt_q;
  logic [REG_W-1:0]  reg_sel_q;
  logic [BYTE_W-1:0] word_val, word_dly;

  assign word_val = mem_data_i[BYTE_W-1:0];
  assign word_dly = mem_data_i[2*BYTE_W-1:BYTE_W];

  trig_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cnt_zero_i (pair_cnt_i == '0),
    .last_i     (last),
    .dly_zero_i (dly_zero),
    .wait_end_i (wait_end),
    .idx_load_o (idx_load),
    .idx_inc_o  (idx_inc),
    .tmr_load_o (tmr_load),
    .wr_o       (wr_o),
    .done_o     (done_o)
  );

  trig_index #(.ADDR_W(ADDR_W)) u_index (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (idx_load),
    .cnt_i  (pair_cnt_i),
    .inc_i  (idx_inc),
    .idx_o  (mem_addr_o),
    .cnt_o  (pair_cnt_q),
    .last_o (last)
  );

  trig_timer #(.DLY_W(BYTE_W), .CYC_PER_US(CYC_PER_US)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .dly_i  (word_dly),
    .zero_o (dly_zero),
    .end_o  (wait_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_sel_q <= '0;
    else if (idx_load) reg_sel_q <= reg_sel_i;
  end

  assign wr_addr_o = reg_sel_q;
  assign wr_data_o = wr_o ? word_val : '0;
endmodule

// File: rtl/trig_gen_chk.sv
module trig_gen_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 6,
  parameter int REG_W  = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_o,
  input logic                done_o,
  input logic [REG_W-1:0]    wr_addr_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [2*BYTE_W-1:0] mem_data_i,
  input logic [ADDR_W:0]     pair_cnt_q
);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_no_wr_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && done_o));

  a_r3_index_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ({1'b0, mem_addr_o} < pair_cnt_q));

  a_r5_zero_hold_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && mem_data_i[2*BYTE_W-1:BYTE_W] == '0 &&
     ({1'b0, mem_addr_o} + (ADDR_W+1)'(1) < pair_cnt_q)) |=> wr_o);

  a_r4_back_to_back_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(wr_o)) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

  a_r8_sel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(wr_o)) |-> $stable(wr_addr_o));
endmodule

bind trig_gen trig_gen_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_o       (wr_o),
  .done_o     (done_o),
  .wr_addr_o  (wr_addr_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_i (mem_data_i),
  .pair_cnt_q (pair_cnt_q)
);

// File: tb/trig_gen_tb.sv
module trig_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K          = 4;
  localparam int DEPTH      = 64;

  typedef struct {
    bit       wr;
    bit       done;
    bit [7:0] data;
    int       idx;
    int       sel;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [6:0]  pair_cnt_i = '0;
  logic [5:0]  mem_addr_o;
  logic [15:0] mem_data_i;
  logic        wr_o;
  logic [2:0]  wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        done_o;

  logic [15:0] mem [DEPTH];
  exp_t        q[$];
  int          errors = 0;
  int          checks = 0;
  int          nstrobe = 0;
  int          ndone = 0;
  string       scen = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_data_i = mem[mem_addr_o];

  trig_gen #(.CYC_PER_US(K)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .reg_sel_i  (reg_sel_i),
    .pair_cnt_i (pair_cnt_i),
    .mem_addr_o (mem_addr_o),
    .mem_data_i (mem_data_i),
    .wr_o       (wr_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", tag, scen, what, act, exp);
    end
  endtask

  task automatic build(input int sel, input int cnt);
    exp_t e;
    if (cnt != 0) begin
      for (int i = 0; i < cnt; i++) begin
        e = '{wr: 1'b1, done: 1'b0, data: mem[i][7:0], idx: i, sel: sel};
        q.push_back(e);
        for (int j = 0; j < int'(mem[i][15:8]) * K; j++) begin
          e = '{wr: 1'b0, done: 1'b0, data: 8'd0, idx: 0, sel: 0};
          q.push_back(e);
        end
      end
    end
    e = '{wr: 1'b0, done: 1'b1, data: 8'd0, idx: 0, sel: 0};
    q.push_back(e);
  endtask

  // one cycle: compare the current outputs with the model, then drive the next inputs
  task automatic step(input bit st, input int sel, input int cnt);
    exp_t e;
    bit   popped;
    @(negedge clk);
    popped = (q.size() > 0);
    if (popped) e = q.pop_front();
    else        e = '{wr: 1'b0, done: 1'b0, data: 8'd0, idx: 0, sel: 0};
    check(wr_o == e.wr, "R4", "wr_o timing", int'(wr_o), int'(e.wr));
    check(done_o == e.done, "R6", "done_o timing", int'(done_o), int'(e.done));
    check(wr_data_o == e.data, "R9", "wr_data_o", int'(wr_data_o), int'(e.data));
    if (e.wr) begin
      check(int'(mem_addr_o) == e.idx, "R3", "mem_addr_o", int'(mem_addr_o), e.idx);
      check(int'(wr_addr_o) == e.sel, "R2", "wr_addr_o", int'(wr_addr_o), e.sel);
    end
    if (wr_o)   nstrobe++;
    if (done_o) ndone++;
    start_i    = st;
    reg_sel_i  = 3'(sel);
    pair_cnt_i = 7'(cnt);
    if (st && !popped) build(sel, cnt);
  endtask

  task automatic run(input int sel, input int cnt);
    nstrobe = 0;
    ndone   = 0;
    step(1'b1, sel, cnt);
    while (q.size() > 0) step(1'b0, 0, 0);
    step(1'b0, 0, 0);
    check(nstrobe == cnt, "R9", "strobe count", nstrobe, cnt);
    check(ndone == 1, "R6", "done count", ndone, 1);
  endtask

  task automatic main_seq();
    for (int i = 0; i < DEPTH; i++) mem[i] = {8'(i % 4), 8'(i * 37 + 5)};
    // R1: reset state
    #(CLK_PERIOD * 2);
    check(wr_o == 1'b0, "R1", "wr_o in reset", int'(wr_o), 0);
    check(done_o == 1'b0, "R1", "done_o in reset", int'(done_o), 0);
    check(mem_addr_o == '0, "R1", "mem_addr_o in reset", int'(mem_addr_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);

    // R2/R3/R4: mixed holds
    scen = "R4";
    mem[0] = {8'd2, 8'hA5};
    mem[1] = {8'd1, 8'h3C};
    mem[2] = {8'd3, 8'hFF};
    run(5, 3);

    // R5: all holds zero, back-to-back strobes
    scen = "R5";
    for (int i = 0; i < 4; i++) mem[i] = {8'd0, 8'(8'h11 * (i + 1))};
    run(2, 4);

    // R7: zero count
    scen = "R7";
    run(6, 0);

    // R8: starts during a run and in the done cycle are ignored
    scen = "R8";
    mem[0] = {8'd2, 8'h81};
    mem[1] = {8'd1, 8'h42};
    nstrobe = 0;
    ndone   = 0;
    step(1'b1, 1, 2);
    for (int i = 0; i < 4; i++) step(1'b1, 7, 5);
    while (q.size() > 1) step(1'b0, 0, 0);
    step(1'b1, 7, 5);
    for (int i = 0; i < 6; i++) step(1'b0, 0, 0);
    check(nstrobe == 2, "R8", "strobes with ignored starts", nstrobe, 2);
    check(ndone == 1, "R8", "done pulses with ignored starts", ndone, 1);

    // R3: full table, last index
    scen = "R3";
    for (int i = 0; i < DEPTH; i++) mem[i] = {8'(i % 3), 8'(i * 53 + 9)};
    run(3, DEPTH);

    // R6: single entry with a long hold
    scen = "R6";
    mem[0] = {8'd255, 8'h5A};
    run(4, 1);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule